// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block is a clocked single-port memory with a shared data bus. Its word is split into byte lanes of nine bits, four lanes by default, which makes a 36-bit word. The depth is a parameter. Every control, address and write-data input is sampled on the rising clock edge. Read data leaves through an output register, so a read returns one cycle after its address is taken. The output-enable input is not clocked and gates the bus drivers directly. The bidirectional bus is split into a data-in vector, a data-out vector and a drive-enable.

Three chip selects and two address strobes decide what each edge does. A host-side strobe always opens a read. It can turn into a write only on the following edge, so that write takes two cycles. A controller-side strobe can write on the same edge it is sampled. On edges with no strobe, the open access continues at the captured address: it either reads the same word again or writes it. Address advance within a burst belongs to a separate block and is not part of this one.

The drivers are turned off in several cases:
- on any write;
- on a deselect;
- in the first cycle of an access that starts from the deselected state;
- after a write, until a strobe opens a new read.

Top module: `pipe_sync_sram`

## Requirements
- R1: An access starts at an edge only if a strobe is low and the chip selects are active: `csel_a_ni`=0, `csel_b_i`=1 and `csel_c_ni`=0. A counted strobe with any chip select inactive is a deselect and writes nothing.
- R2: If both strobes are low, the host strobe wins and the edge is a read. The host strobe counts only while `csel_a_ni` is 0. If it is low while `csel_a_ni` is 1 and the controller strobe is high, the edge behaves as if no strobe were present.
- R3: An edge that starts an access with the host strobe is always a read and writes nothing, whatever the write inputs are. On the next edge without a strobe, an active write request writes the captured address.
- R4: A controller strobe, with the host strobe high and a write request present, writes `dq_i` to `addr_i` on that same edge.
- R5: When `gwr_ni` is 0, a write stores all four lanes. Lane k is bits [9k+8:9k].
- R6: When `gwr_ni` is 1, a write happens only if `bwr_ni` is 0. It stores just the lanes whose `lane_ni` bit is 0, and the other lanes keep their contents. If `bwr_ni` is 1, or all `lane_ni` bits are 1, there is no write and the edge is a read.
- R7: Read latency is one cycle. The word at the address captured at edge k is on `dq_o`, with `dq_oe_o`=1, after edge k+1, provided `oe_ni`=0 and edge k+1 is neither a write nor a deselect.
- R8: `dq_oe_o` is 0 in the cycle after any write edge, whatever `oe_ni` is. After a write it stays 0 on edges with no strobe until a strobe starts a new read.
- R9: In the cycle after an access that starts from the deselected state, `dq_oe_o` is 0 even with `oe_ni`=0.
- R10: A deselect edge turns `dq_oe_o` off from that edge on. While the block is deselected, edges with no strobe write nothing.
- R11: `dq_oe_o` is 1 only while `oe_ni` is 0, and follows `oe_ni` without waiting for a clock edge.
- R12: During and after reset the block is deselected and `dq_oe_o` is 0.
- R13: During a read with no strobe present, each edge returns the word at the same captured address again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low reset |
| csel_a_ni | input | 1 | Chip select A, active low; also qualifies the host strobe |
| csel_b_i | input | 1 | Chip select B, active high |
| csel_c_ni | input | 1 | Chip select C, active low |
| stb_host_ni | input | 1 | Host address strobe, active low |
| stb_ctrl_ni | input | 1 | Controller address strobe, active low |
| addr_i | input | AW | Word address |
| gwr_ni | input | 1 | Global write, active low |
| bwr_ni | input | 1 | Byte write enable, active low |
| lane_ni | input | LANES | Per-lane write select, active low |
| oe_ni | input | 1 | Output enable, active low, not clocked |
| dq_i | input | DW | Write data from the bus |
| dq_o | output | DW | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
A wrong cycle decode shows in two ways. A lane may take a write it should not, or miss one it should. Either error shows up at the ports only on the next read of that address, so each scenario reads its words back against a reference copy. A stale session or read-valid flag shows as `dq_oe_o` rising one cycle early or late around deselects and writes. That is visible in the cycle right after the edge, so the drive enable is sampled after every edge where it should change.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_START_RD,
    CYC_START_WR,
    CYC_CONT_RD,
    CYC_CONT_WR
  } cyc_e;

  function automatic logic chips_on(input logic a_n, input logic b, input logic c_n);
    return !a_n && b && !c_n;
  endfunction

  // host strobe only counts while select A is low
  function automatic logic strobe_seen(input logic host_n, input logic ctrl_n, input logic a_n);
    return (!host_n && !a_n) || !ctrl_n;
  endfunction

  function automatic logic is_start(input cyc_e k);
    return (k == CYC_START_RD) || (k == CYC_START_WR);
  endfunction

  function automatic logic is_write(input cyc_e k);
    return (k == CYC_START_WR) || (k == CYC_CONT_WR);
  endfunction

  function automatic logic is_read(input cyc_e k);
    return (k == CYC_START_RD) || (k == CYC_CONT_RD);
  endfunction

endpackage

// File: rtl/ssr_decode.sv
module ssr_decode
  import ssr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             csel_a_ni,
  input  logic             csel_b_i,
  input  logic             csel_c_ni,
  input  logic             stb_host_ni,
  input  logic             stb_ctrl_ni,
  input  logic             gwr_ni,
  input  logic             bwr_ni,
  input  logic [LANES-1:0] lane_ni,
  input  logic             sel_q_i,
  input  logic             rd_mode_q_i,
  output cyc_e             kind_o,
  output logic [LANES-1:0] lane_we_o
);

  logic             on, seen, wreq;
  logic [LANES-1:0] mask;

  always_comb begin
    on   = chips_on(csel_a_ni, csel_b_i, csel_c_ni);
    seen = strobe_seen(stb_host_ni, stb_ctrl_ni, csel_a_ni);
    wreq = !gwr_ni || (!bwr_ni && (lane_ni != '1));
    if (!gwr_ni)      mask = '1;
    else if (!bwr_ni) mask = ~lane_ni;
    else              mask = '0;

    kind_o = CYC_IDLE;
    if (seen && !on)            kind_o = CYC_DESEL;
    else if (seen && !stb_host_ni) kind_o = CYC_START_RD;  // host strobe wins, always a read
    else if (seen)              kind_o = wreq ? CYC_START_WR : CYC_START_RD;
    else if (sel_q_i && wreq)   kind_o = CYC_CONT_WR;
    else if (sel_q_i && rd_mode_q_i) kind_o = CYC_CONT_RD;

    lane_we_o = is_write(kind_o) ? mask : '0;
  end

endmodule

// File: rtl/ssr_lane_ram.sv
module ssr_lane_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int W     = 9
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/ssr_out_stage.sv
module ssr_out_stage #(
  parameter int DW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_pend_i,
  input  logic [DW-1:0] rd_word_i,
  input  logic          kill_i,
  input  logic          wake_i,
  input  logic          oe_ni,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          valid_o,
  output logic          mask_o
);

  logic [DW-1:0] data_q;
  logic          vld_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      vld_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (rd_pend_i) data_q <= rd_word_i;
      vld_q  <= rd_pend_i && !kill_i;
      mask_q <= wake_i;
    end
  end

  assign dq_o    = data_q;
  assign dq_oe_o = !oe_ni && vld_q && !mask_q;
  assign valid_o = vld_q;
  assign mask_o  = mask_q;

endmodule

// File: rtl/pipe_sync_sram.sv
module pipe_sync_sram
  import ssr_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csel_a_ni,
  input  logic             csel_b_i,
  input  logic             csel_c_ni,
  input  logic             stb_host_ni,
  input  logic             stb_ctrl_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             gwr_ni,
  input  logic             bwr_ni,
  input  logic [LANES-1:0] lane_ni,
  input  logic             oe_ni,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o
);

  cyc_e             cyc_kind;
  logic [LANES-1:0] lane_we;
  logic [AW-1:0]    addr_q, wr_addr;
  logic             sel_q, rd_mode_q, rd_pend_q;
  logic             start_ev, write_ev, desel_ev, wake_ev, kill_ev;
  logic             valid_q, mask_q;
  logic [DW-1:0]    rd_word;

  ssr_decode #(.LANES(LANES)) u_dec (
    .csel_a_ni   (csel_a_ni),
    .csel_b_i    (csel_b_i),
    .csel_c_ni   (csel_c_ni),
    .stb_host_ni (stb_host_ni),
    .stb_ctrl_ni (stb_ctrl_ni),
    .gwr_ni      (gwr_ni),
    .bwr_ni      (bwr_ni),
    .lane_ni     (lane_ni),
    .sel_q_i     (sel_q),
    .rd_mode_q_i (rd_mode_q),
    .kind_o      (cyc_kind),
    .lane_we_o   (lane_we)
  );

  assign start_ev = is_start(cyc_kind);
  assign write_ev = is_write(cyc_kind);
  assign desel_ev = (cyc_kind == CYC_DESEL);
  assign wake_ev  = start_ev && !sel_q;
  assign kill_ev  = write_ev || desel_ev;
  assign wr_addr  = (cyc_kind == CYC_START_WR) ? addr_i : addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      sel_q     <= 1'b0;
      rd_mode_q <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      if (start_ev) begin
        addr_q <= addr_i;
        sel_q  <= 1'b1;
      end else if (desel_ev) begin
        sel_q  <= 1'b0;
      end
      if (cyc_kind == CYC_START_RD)   rd_mode_q <= 1'b1;
      else if (kill_ev)               rd_mode_q <= 1'b0;
      rd_pend_q <= is_read(cyc_kind);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ssr_lane_ram #(.DEPTH(DEPTH), .AW(AW), .W(LANE_W)) u_ram (
      .clk_i   (clk_i),
      .we_i    (lane_we[g]),
      .waddr_i (wr_addr),
      .wdata_i (dq_i[g*LANE_W +: LANE_W]),
      .raddr_i (addr_q),
      .rdata_o (rd_word[g*LANE_W +: LANE_W])
    );
  end

  ssr_out_stage #(.DW(DW)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_pend_i (rd_pend_q),
    .rd_word_i (rd_word),
    .kill_i    (kill_ev),
    .wake_i    (wake_ev),
    .oe_ni     (oe_ni),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o),
    .valid_o   (valid_q),
    .mask_o    (mask_q)
  );

endmodule

// File: rtl/ssr_checks.sv
module ssr_checks
  import ssr_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csel_a_ni,
  input logic             csel_b_i,
  input logic             csel_c_ni,
  input logic             stb_host_ni,
  input logic             stb_ctrl_ni,
  input logic             gwr_ni,
  input logic             oe_ni,
  input logic             dq_oe_o,
  input cyc_e             cyc_kind,
  input logic [LANES-1:0] lane_we,
  input logic             sel_q,
  input logic             kill_ev,
  input logic             valid_q
);

  assert_start_needs_sel_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_start(cyc_kind) |-> (!csel_a_ni && csel_b_i && !csel_c_ni));

  assert_host_no_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb_host_ni && !csel_a_ni && csel_b_i && !csel_c_ni) |-> (lane_we == '0));

  assert_global_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gwr_ni && stb_host_ni && !stb_ctrl_ni && !csel_a_ni && csel_b_i && !csel_c_ni)
      |-> (lane_we == '1));

  assert_rd_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_kind == CYC_START_RD) ##1 !kill_ev |=> valid_q);

  assert_write_hiz_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_write(cyc_kind) |=> !dq_oe_o);

  assert_wake_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_start(cyc_kind) && !sel_q) |=> !dq_oe_o);

  assert_desel_hiz_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_kind == CYC_DESEL) |=> !dq_oe_o);

  assert_idle_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_q && stb_ctrl_ni && (stb_host_ni || csel_a_ni)) |-> (lane_we == '0));

  assert_oe_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);

endmodule

bind pipe_sync_sram ssr_checks #(.LANES(LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csel_a_ni   (csel_a_ni),
  .csel_b_i    (csel_b_i),
  .csel_c_ni   (csel_c_ni),
  .stb_host_ni (stb_host_ni),
  .stb_ctrl_ni (stb_ctrl_ni),
  .gwr_ni      (gwr_ni),
  .oe_ni       (oe_ni),
  .dq_oe_o     (dq_oe_o),
  .cyc_kind    (cyc_kind),
  .lane_we     (lane_we),
  .sel_q       (sel_q),
  .kill_ev     (kill_ev),
  .valid_q     (valid_q)
);

// File: tb/tb_pipe_sync_sram.sv
module tb_pipe_sync_sram;
  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam int LANES = 4;
  localparam int DW    = 36;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, a_n, b, c_n, host_n, ctrl_n, gw_n, bw_n, oe_n;
  logic [AW-1:0]    addr;
  logic [LANES-1:0] lanes_n;
  logic [DW-1:0]    din, dout;
  logic             doe;

  pipe_sync_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(9)) dut (
    .clk_i(clk), .rst_ni(rst_n), .csel_a_ni(a_n), .csel_b_i(b), .csel_c_ni(c_n),
    .stb_host_ni(host_n), .stb_ctrl_ni(ctrl_n), .addr_i(addr), .gwr_ni(gw_n),
    .bwr_ni(bw_n), .lane_ni(lanes_n), .oe_ni(oe_n), .dq_i(din), .dq_o(dout), .dq_oe_o(doe)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] ref_mem [int];

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    host_n = 1; ctrl_n = 1; gw_n = 1; bw_n = 1; lanes_n = '1;
    a_n = 0; b = 1; c_n = 0; din = '0;
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w, input logic [DW-1:0] new_w,
                                          input logic [LANES-1:0] en);
    logic [DW-1:0] r = old_w;
    for (int k = 0; k < LANES; k++) if (en[k]) r[k*9 +: 9] = new_w[k*9 +: 9];
    return r;
  endfunction

  function automatic logic [LANES-1:0] wr_lanes(input logic g, input logic bb, input logic [LANES-1:0] l);
    if (!g) return '1;
    if (!bb) return ~l;
    return '0;
  endfunction

  // controller-strobe write; bus must be off in the following cycle
  task automatic ctrl_write(input logic [AW-1:0] ad, input logic [DW-1:0] d, input logic g,
                            input logic bb, input logic [LANES-1:0] l, input string tag);
    logic [DW-1:0] old_w = ref_mem.exists(int'(ad)) ? ref_mem[int'(ad)] : '0;
    idle(); ctrl_n = 0; addr = ad; din = d; gw_n = g; bw_n = bb; lanes_n = l;
    tick();
    check(doe == 1'b0, {tag, " R8 write cycle drive"}, DW'(doe), '0);
    ref_mem[int'(ad)] = merge(old_w, d, wr_lanes(g, bb, l));
    idle();
  endtask

  task automatic read_chk(input logic [AW-1:0] ad, input string tag);
    idle(); ctrl_n = 0; addr = ad;
    tick();
    idle();
    tick();
    check(doe == 1'b1 && dout == ref_mem[int'(ad)], {tag, " R7 read data"}, doe ? dout : 'z, ref_mem[int'(ad)]);
  endtask

  task automatic deselect(input string tag);
    idle(); ctrl_n = 0; b = 0;
    tick();
    check(doe == 1'b0, {tag, " R10 deselect"}, DW'(doe), '0);
    idle();
  endtask

  task automatic t_reset();
    rst_n = 0; oe_n = 0; addr = '0; idle();
    repeat (3) tick();
    check(doe == 1'b0, "R12 in reset", DW'(doe), '0);
    rst_n = 1;
    tick(); tick();
    check(doe == 1'b0, "R12 after reset", DW'(doe), '0);
  endtask

  task automatic t_global_fill();
    ctrl_write(8'h00, 36'h9_0000_1111, 0, 1, '1, "R4 R5");
    ctrl_write(8'h05, 36'hA_5A5A_5A5A, 0, 0, 4'b0101, "R5 gw overrides");
    ctrl_write(8'h3C, 36'h1_2345_6789, 0, 1, '1, "R4");
    ctrl_write(8'h80, 36'hF_FEDC_BA98, 0, 1, '1, "R4");
    ctrl_write(8'hFF, 36'h7_0F0F_0F0F, 0, 1, '1, "R4");
    read_chk(8'h00, "R4");
    read_chk(8'h05, "R5");
    read_chk(8'hFF, "R4 top address");
  endtask

  task automatic t_wake_mask();
    deselect("R9 pre");
    idle(); ctrl_n = 0; addr = 8'h3C;
    tick();
    check(doe == 1'b0, "R9 first cycle masked", DW'(doe), '0);
    idle();
    tick();
    check(doe == 1'b1 && dout == ref_mem[8'h3C], "R7 after wake", dout, ref_mem[8'h3C]);
  endtask

  task automatic t_host_write();
    logic [DW-1:0] d = 36'h3_CAFE_BEEF;
    idle(); host_n = 0; addr = 8'h80; gw_n = 0; din = 36'h0_DEAD_0000;
    tick();
    idle(); bw_n = 0; lanes_n = 4'b1010; din = d;
    tick();
    check(doe == 1'b0, "R8 host second-cycle write drive", DW'(doe), '0);
    ref_mem[8'h80] = merge(ref_mem[8'h80], d, 4'b0101);
    idle();
    tick();
    check(doe == 1'b0, "R8 stays off after write", DW'(doe), '0);
    read_chk(8'h80, "R3 R6 host two-cycle lane write");
  endtask

  task automatic t_both_strobes();
    idle(); host_n = 0; ctrl_n = 0; addr = 8'h3C; gw_n = 0; din = 36'h0_BAD0_BAD0;
    tick();
    idle();
    tick();
    check(doe == 1'b1 && dout == ref_mem[8'h3C], "R2 both strobes read", dout, ref_mem[8'h3C]);
    read_chk(8'h3C, "R2 no write");
  endtask

  task automatic t_host_ignored();
    read_chk(8'h00, "R2 setup");
    idle(); a_n = 1; host_n = 0; addr = 8'hFF;
    tick();
    check(doe == 1'b1 && dout == ref_mem[8'h00], "R2 host strobe ignored", dout, ref_mem[8'h00]);
    idle(); a_n = 1; ctrl_n = 0;
    tick();
    check(doe == 1'b0, "R1 controller strobe with select A off", DW'(doe), '0);
    idle();
  endtask

  task automatic t_selects();
    read_chk(8'h05, "R1 setup");
    idle(); ctrl_n = 0; b = 0; gw_n = 0; addr = 8'h05; din = 36'h0_1111_2222;
    tick();
    check(doe == 1'b0, "R1 select B off", DW'(doe), '0);
    idle();
    tick();
    check(doe == 1'b0, "R1 stays deselected", DW'(doe), '0);
    idle(); ctrl_n = 0; c_n = 1; gw_n = 0; addr = 8'h05; din = 36'h0_3333_4444;
    tick();
    idle();
    read_chk(8'h05, "R1 no write on deselect");
  endtask

  task automatic t_bytes();
    ctrl_write(8'hFF, 36'h8_AAAA_5555, 1, 0, 4'b0110, "R6 lanes 0 and 3");
    read_chk(8'hFF, "R6 merged");
    idle(); ctrl_n = 0; addr = 8'hFF; bw_n = 1; lanes_n = 4'b0000; din = 36'h0;
    tick();
    idle();
    tick();
    check(doe == 1'b1 && dout == ref_mem[8'hFF], "R6 byte enable high is read", dout, ref_mem[8'hFF]);
    idle(); ctrl_n = 0; addr = 8'hFF; bw_n = 0; lanes_n = 4'b1111; din = 36'h0;
    tick();
    idle();
    tick();
    check(doe == 1'b1 && dout == ref_mem[8'hFF], "R6 no lane selected is read", dout, ref_mem[8'hFF]);
  endtask

  task automatic t_oe();
    read_chk(8'h3C, "R11 setup");
    oe_n = 1; #1;
    check(doe == 1'b0, "R11 oe high", DW'(doe), '0);
    oe_n = 0; #1;
    check(doe == 1'b1 && dout == ref_mem[8'h3C], "R11 oe low", dout, ref_mem[8'h3C]);
  endtask

  task automatic t_cont_read();
    read_chk(8'h80, "R13 setup");
    for (int i = 0; i < 3; i++) begin
      tick();
      check(doe == 1'b1 && dout == ref_mem[8'h80], "R13 repeat same word", dout, ref_mem[8'h80]);
    end
  endtask

  task automatic t_desel_nowrite();
    read_chk(8'h00, "R10 setup");
    deselect("R10");
    idle(); gw_n = 0; din = 36'h0_5555_AAAA;
    tick(); tick();
    idle();
    read_chk(8'h00, "R10 no write while deselected");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    t_reset();
    t_global_fill();
    t_wake_mask();
    t_host_write();
    t_both_strobes();
    t_host_ignored();
    t_selects();
    t_bytes();
    t_oe();
    t_cont_read();
    t_desel_nowrite();
    summary();
  end

endmodule